// File: doc/BRIEF.md
# Two-wire serial register slave with strapped address

This block sits on a two-wire serial bus as a target and moves 8-bit bytes between an external host and an internal command interface. The host always owns the clock line. The block only answers. Its 7-bit bus address is fixed in its upper five bits. The two lowest bits come from two strap pins, so up to four of these blocks can share one bus at addresses 0x1C to 0x1F.

Both bus lines pass through a two-flop synchroniser and a short majority-free glitch filter before any decoding. The filtered lines are decoded into START, STOP and clock edges. A matching address with a write direction leads to data bytes. Each data byte is acknowledged and handed to the core with a one-cycle valid pulse. A matching address with a read direction leads to bytes that the core supplies, each one fetched with a one-cycle request pulse. The data line is only ever pulled low (`sda_oe`) and relies on an external pull-up.

A repeated START is not honoured. Once a transaction has begun, a second START makes the block go quiet until a STOP is seen, so the host must close every transfer with a STOP.

Top module: `i2c_strap_slave`

## Requirements
- R1: After reset, `sda_oe`, `rx_valid` and `rd_req` are all 0.
- R2: The address byte is sent MSB first. Its upper seven bits must equal 0,0,1,1,1,`strap_a2`,`strap_a1` (strap low gives 0, strap high gives 1), and bit 0 is the direction (0 write, 1 read). On a match the block pulls SDA low through the ninth clock.
- R3: On a non-matching address the block does not acknowledge. Until the next STOP it neither acknowledges nor delivers any further byte.
- R4: In a write transfer every data byte is acknowledged in its ninth clock. It appears on `rx_data` (first bit received = bit 7) together with a `rx_valid` pulse lasting exactly one clock.
- R5: In a read transfer `rd_req` pulses once after the address byte, before the acknowledge slot ends. The block samples `tx_data` at the SCL falling edge that ends the acknowledge slot and shifts it out MSB first.
- R6: After each read byte, a master acknowledge (SDA low in the ninth clock) produces one more `rd_req` and the next byte. A master not-acknowledge makes the block release SDA and issue no further `rd_req`.
- R7: A START seen while a transaction is open (repeated START) releases SDA. The block then ignores all bytes, without acknowledge or `rx_valid`, until a STOP.
- R8: After a STOP (SDA rising while SCL high), a START (SDA falling while SCL high) followed by a matching address begins a new transfer normally.
- R9: A pulse on SCL shorter than `FILT_LEN` clock cycles is ignored and clocks no bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| strap_a1 | input | 1 | Address bit 0 strap (static) |
| strap_a2 | input | 1 | Address bit 1 strap (static) |
| rx_data | output | 8 | Last received write byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is new |
| rd_req | output | 1 | One-cycle pulse asking the core for the next read byte |
| tx_data | input | 8 | Read byte supplied by the core |

## Verification
A change on a bus pin reaches the block's outputs 4 + `FILT_LEN` clocks later: two synchroniser flops, the filter stages, the filtered-line register and the state register. With the default filter that is seven cycles. The bench holds each bus line level for sixteen cycles per quarter bit. It samples the acknowledge and read bits halfway through the SCL high phase, well after that latency and before the next bus change. The `rx_valid` and `rd_req` pulses are counted on the falling clock edge, so each one-cycle pulse is seen exactly once.

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave #(
  parameter int unsigned FILT_LEN = 3,
  parameter logic [4:0]  ADDR_HI  = 5'b00111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       strap_a1,
  input  logic       strap_a2,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rd_req,
  input  logic [7:0] tx_data
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK, ST_HOLD
  } st_t;

  logic [1:0] scl_sy, sda_sy;
  logic [FILT_LEN-1:0] scl_h, sda_h;
  logic scl_q, sda_q, scl_p, sda_p;
  st_t  st;
  logic [3:0] cnt;
  logic [7:0] sr, txsr;
  logic mack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11;
      scl_h <= '1; sda_h <= '1;
      scl_q <= 1'b1; sda_q <= 1'b1;
      scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_h  <= {scl_h[FILT_LEN-2:0], scl_sy[1]};
      sda_h  <= {sda_h[FILT_LEN-2:0], sda_sy[1]};
      if (&scl_h) scl_q <= 1'b1; else if (~|scl_h) scl_q <= 1'b0;
      if (&sda_h) sda_q <= 1'b1; else if (~|sda_h) sda_q <= 1'b0;
      scl_p <= scl_q;
      sda_p <= sda_q;
    end
  end

  wire start_det = scl_q & scl_p & sda_p & ~sda_q;
  wire stop_det  = scl_q & scl_p & ~sda_p & sda_q;
  wire scl_rise  = scl_q & ~scl_p;
  wire scl_fall  = ~scl_q & scl_p;
  wire addr_hit  = sr[7:1] == {ADDR_HI, strap_a2, strap_a1};
  wire [7:0] sr_nx = {sr[6:0], sda_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sr <= '0; txsr <= '0; mack <= 1'b0;
      sda_oe <= 1'b0; rx_data <= '0; rx_valid <= 1'b0; rd_req <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rd_req   <= 1'b0;
      if (stop_det) begin
        st <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        sda_oe <= 1'b0;
        cnt <= '0;
        st <= (st == ST_IDLE) ? ST_ADDR : ST_HOLD;
      end else if (scl_rise) begin
        case (st)
          ST_ADDR, ST_WR: begin
            sr  <= sr_nx;
            cnt <= cnt + 4'd1;
            if (st == ST_WR && cnt == 4'd7) begin
              rx_data  <= sr_nx;
              rx_valid <= 1'b1;
            end
          end
          ST_RACK: begin
            mack   <= ~sda_q;
            rd_req <= ~sda_q;
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        case (st)
          ST_ADDR: if (cnt == 4'd8) begin
            cnt <= '0;
            if (addr_hit) begin
              st <= ST_AACK;
              sda_oe <= 1'b1;
              rd_req <= sr[0];
            end else begin
              st <= ST_HOLD;
            end
          end
          ST_WR: if (cnt == 4'd8) begin
            cnt <= '0;
            st <= ST_WACK;
            sda_oe <= 1'b1;
          end
          ST_AACK: begin
            if (sr[0]) begin
              st <= ST_RD;
              sda_oe <= ~tx_data[7];
              txsr <= {tx_data[6:0], 1'b0};
            end else begin
              st <= ST_WR;
              sda_oe <= 1'b0;
            end
          end
          ST_WACK: begin
            st <= ST_WR;
            sda_oe <= 1'b0;
          end
          ST_RD: begin
            if (cnt == 4'd7) begin
              st <= ST_RACK;
              sda_oe <= 1'b0;
              cnt <= '0;
            end else begin
              sda_oe <= ~txsr[7];
              txsr <= {txsr[6:0], 1'b0};
              cnt <= cnt + 4'd1;
            end
          end
          ST_RACK: begin
            if (mack) begin
              st <= ST_RD;
              sda_oe <= ~tx_data[7];
              txsr <= {tx_data[6:0], 1'b0};
            end else begin
              st <= ST_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R4
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rd_req));

  // R2
  oe_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  // R7
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) |-> !sda_oe);

endmodule

// File: tb/i2c_strap_slave_tb_top.sv
module i2c_strap_slave_tb_top;
  localparam int Q = 16;
  localparam int NV = 6;
  // {a2,a1, addr7, data8, match}
  localparam logic [17:0] VEC [NV] = '{
    {2'b00, 7'h1C, 8'h5A, 1'b1},
    {2'b01, 7'h1D, 8'hC3, 1'b1},
    {2'b10, 7'h1E, 8'h00, 1'b1},
    {2'b11, 7'h1F, 8'hFF, 1'b1},
    {2'b11, 7'h1C, 8'h81, 1'b0},
    {2'b00, 7'h3C, 8'h7E, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic a1 = 1'b0, a2 = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic sda_oe, rx_valid, rd_req;
  logic [7:0] rx_data;
  wire sda_line = m_sda & ~sda_oe;
  int checks = 0, fails = 0, rx_cnt = 0, rd_cnt = 0;
  logic [7:0] rx_last = 8'h00;
  logic [7:0] rd_list [4] = '{8'hA5, 8'h3C, 8'hF0, 8'h99};

  always #2.5 clk = ~clk;

  i2c_strap_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_a1(a1), .strap_a2(a2),
    .rx_data(rx_data), .rx_valid(rx_valid), .rd_req(rd_req), .tx_data(tx_data));

  always @(negedge clk) begin
    if (rx_valid) begin rx_cnt <= rx_cnt + 1; rx_last <= rx_data; end
    if (rd_req) begin tx_data <= rd_list[rd_cnt % 4]; rd_cnt <= rd_cnt + 1; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, input int glitch_bit, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; qw(); m_scl = 1'b1; qw();
      if (i == glitch_bit) begin
        @(negedge clk) m_scl = 1'b0;
        @(negedge clk) m_scl = 1'b1;
      end
      qw(); m_scl = 1'b0;
      if (i == glitch_bit) begin
        @(negedge clk) m_scl = 1'b1;
        @(negedge clk) m_scl = 1'b0;
      end
      qw();
    end
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw();
    ack = (sda_line == 1'b0);
    qw(); m_scl = 1'b0; qw();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; qw(); m_scl = 1'b1; qw();
      b[i] = sda_line;
      qw(); m_scl = 1'b0; qw();
    end
    m_sda = give_ack ? 1'b0 : 1'b1; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
    m_sda = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit ack;
    int rx0, rd0;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    chk(rd_req == 1'b0, "R1 rd_req", rd_req, 0);
    rst_n = 1'b1;
    qw();

    // R2 R3 R4: table of write transfers
    for (int v = 0; v < NV; v++) begin
      {a2, a1} = VEC[v][17:16];
      rx0 = rx_cnt;
      bus_start();
      send_byte({VEC[v][15:9], 1'b0}, -1, ack);
      chk(ack == VEC[v][0], VEC[v][0] ? "R2 address ack" : "R3 address nack", ack, VEC[v][0]);
      send_byte(VEC[v][8:1], -1, ack);
      chk(ack == VEC[v][0], VEC[v][0] ? "R4 data ack" : "R3 data ignored", ack, VEC[v][0]);
      chk(rx_cnt == rx0 + int'(VEC[v][0]), "R4 rx_valid count", rx_cnt, rx0 + int'(VEC[v][0]));
      if (VEC[v][0]) chk(rx_last == VEC[v][8:1], "R4 rx_data", rx_last, VEC[v][8:1]);
      bus_stop();
    end

    // R4 two bytes in one transfer, R9 glitch inside second byte
    {a2, a1} = 2'b00;
    rx0 = rx_cnt;
    bus_start();
    send_byte(8'h38, -1, ack);
    send_byte(8'h12, -1, ack);
    chk(rx_last == 8'h12, "R4 first of two", rx_last, 8'h12);
    send_byte(8'hB6, 4, ack);
    chk(ack == 1'b1, "R9 ack after glitch", ack, 1);
    chk(rx_last == 8'hB6, "R9 glitch ignored", rx_last, 8'hB6);
    chk(rx_cnt == rx0 + 2, "R4 two pulses", rx_cnt, rx0 + 2);
    bus_stop();

    // R7 repeated START
    rx0 = rx_cnt;
    bus_start();
    send_byte(8'h38, -1, ack);
    send_byte(8'h11, -1, ack);
    bus_start();
    send_byte(8'h38, -1, ack);
    chk(ack == 1'b0, "R7 address after restart", ack, 0);
    send_byte(8'h22, -1, ack);
    chk(ack == 1'b0, "R7 data after restart", ack, 0);
    chk(rx_cnt == rx0 + 1, "R7 rx count", rx_cnt, rx0 + 1);
    chk(rx_last == 8'h11, "R7 rx_data kept", rx_last, 8'h11);
    bus_stop();

    // R8 new transfer after STOP
    bus_start();
    send_byte(8'h38, -1, ack);
    chk(ack == 1'b1, "R8 address ack after stop", ack, 1);
    send_byte(8'h33, -1, ack);
    chk(rx_last == 8'h33, "R8 rx_data", rx_last, 8'h33);
    bus_stop();

    // R5 R6 read transfer
    {a2, a1} = 2'b10;
    rd0 = rd_cnt;
    bus_start();
    send_byte({7'h1E, 1'b1}, -1, ack);
    chk(ack == 1'b1, "R5 read address ack", ack, 1);
    chk(rd_cnt == rd0 + 1, "R5 rd_req after address", rd_cnt, rd0 + 1);
    recv_byte(1'b1, b);
    chk(b == rd_list[rd0 % 4], "R5 first read byte", b, rd_list[rd0 % 4]);
    chk(rd_cnt == rd0 + 2, "R6 rd_req after master ack", rd_cnt, rd0 + 2);
    recv_byte(1'b1, b);
    chk(b == rd_list[(rd0 + 1) % 4], "R6 second read byte", b, rd_list[(rd0 + 1) % 4]);
    recv_byte(1'b0, b);
    chk(b == rd_list[(rd0 + 2) % 4], "R6 third read byte", b, rd_list[(rd0 + 2) % 4]);
    qw();
    chk(rd_cnt == rd0 + 3, "R6 no rd_req after nack", rd_cnt, rd0 + 3);
    chk(sda_oe == 1'b0, "R6 released after nack", sda_oe, 0);
    bus_stop();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule